// File: doc/BRIEF.md
# Alternating Read/Write Start Arbiter

This block sits in front of a burst memory whose read and write ports share one address bus. Every transfer on either port lasts two command cycles. On each rising edge of the command clock the block samples two active-low port selects and decides which transaction, if any, begins. It then emits a one-cycle start pulse for the winner, together with the address captured on that edge, so that the burst sequencer and the data capture logic can proceed.

Two transactions of the same kind may not begin on back-to-back edges. A second such request is discarded, not queued, and a one-cycle drop flag reports it. When both selects are active on one edge, the kind that began on the previous edge decides the winner, so a caller that holds both selects active gets a strict read, write, read, write pattern.

The arbiter is a three-state machine that records what began on the last edge:
- `LAST_NONE`: nothing began.
- `LAST_RD`: a read began.
- `LAST_WR`: a write began.

Its transitions are:
- From `LAST_NONE`: a read request moves it to `LAST_RD`. Otherwise a write request moves it to `LAST_WR`. Otherwise it stays.
- From `LAST_RD`: a write request moves it to `LAST_WR`. Otherwise it returns to `LAST_NONE`, and any read request in this state is dropped.
- From `LAST_WR`: a read request moves it to `LAST_RD`. Otherwise it returns to `LAST_NONE`, and any write request in this state is dropped.

Top module: `rw_start_arbiter`

## Requirements
- R1: `rd_sel_n` and `wr_sel_n` are active low and are looked at only on the rising clock edge. A decision taken on edge t appears on `rd_start` / `wr_start` for exactly the one cycle that follows edge t.
- R2: A read request on the edge right after an accepted read starts nothing. The same holds for a write request on the edge right after an accepted write.
- R3: If both selects are active and nothing began on the previous edge, a read begins. The write loses without raising a drop flag.
- R4: If both selects are active and a read began on the previous edge, a write begins.
- R5: If both selects are active and a write began on the previous edge, a read begins.
- R6: If both selects are held active starting from the idle state, the starts alternate read, write, read, write, with a read first.
- R7: `rd_start` and `wr_start` are never high in the same cycle.
- R8: `rd_addr` takes the value of `addr` only on the edge where a read is accepted, and `wr_addr` only on the edge where a write is accepted. Otherwise each keeps its value.
- R9: A request discarded under R2 raises `rd_drop` or `wr_drop` for exactly the one cycle after that edge, and never for two cycles in a row.
- R10: The two ports are independent. A single-port request that does not break R2 starts at once, whatever the other port did on the previous edge.
- R11: While `rst_n` is low, every output is 0 and the state is `LAST_NONE`. The first edge after release therefore behaves as if coming from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; all decisions are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read port select, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| addr | input | ADDR_W | Shared address bus |
| rd_start | output | 1 | One-cycle pulse: a read burst begins |
| wr_start | output | 1 | One-cycle pulse: a write burst begins |
| rd_addr | output | ADDR_W | Address of the last accepted read |
| wr_addr | output | ADDR_W | Address of the last accepted write |
| rd_drop | output | 1 | One-cycle pulse: a back-to-back read request was discarded |
| wr_drop | output | 1 | One-cycle pulse: a back-to-back write request was discarded |

## Verification
Every result of this block is due one register stage after the edge that samples the selects. The start pulses, the drop flags and the captured addresses all appear in the cycle just after that edge. The bench therefore applies each vector on a falling edge and lets one rising edge pass. It compares the outputs on the following falling edge, before it drives the next vector. That next vector then sees the state left by the decision just checked, which is how the previous-edge priority rules are exercised.

// File: rtl/rw_arb_pkg.sv
package rw_arb_pkg;
    // What began on the previous command edge
    typedef enum logic [1:0] {
        LAST_NONE = 2'd0,
        LAST_RD   = 2'd1,
        LAST_WR   = 2'd2
    } arb_last_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_RD   = 0;
    localparam int unsigned PORT_WR   = 1;
endpackage

// File: rtl/rw_arb_fsm.sv
module rw_arb_fsm
    import rw_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_go,
    output logic wr_go,
    output logic rd_start,
    output logic wr_start,
    output logic rd_drop,
    output logic wr_drop
);
    arb_last_e cur_q, nxt_d;
    logic      rd_ign_d, wr_ign_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= LAST_NONE;
        else        cur_q <= nxt_d;
    end

    // Arbitration and next state
    always_comb begin
        nxt_d    = LAST_NONE;
        rd_go    = 1'b0;
        wr_go    = 1'b0;
        rd_ign_d = 1'b0;
        wr_ign_d = 1'b0;
        unique case (cur_q)
            LAST_NONE: begin
                if (rd_req) begin
                    rd_go = 1'b1;
                    nxt_d = LAST_RD;
                end else if (wr_req) begin
                    wr_go = 1'b1;
                    nxt_d = LAST_WR;
                end
            end
            LAST_RD: begin
                rd_ign_d = rd_req;
                if (wr_req) begin
                    wr_go = 1'b1;
                    nxt_d = LAST_WR;
                end
            end
            LAST_WR: begin
                wr_ign_d = wr_req;
                if (rd_req) begin
                    rd_go = 1'b1;
                    nxt_d = LAST_RD;
                end
            end
            default: nxt_d = LAST_NONE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_drop <= 1'b0;
            wr_drop <= 1'b0;
        end else begin
            rd_drop <= rd_ign_d;
            wr_drop <= wr_ign_d;
        end
    end

    assign rd_start = (cur_q == LAST_RD);
    assign wr_start = (cur_q == LAST_WR);
endmodule

// File: rtl/rw_arb_addr_reg.sv
module rw_arb_addr_reg #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/rw_start_arbiter.sv
module rw_start_arbiter
    import rw_arb_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_start,
    output logic              wr_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_drop,
    output logic              wr_drop
);
    logic                           rd_go, wr_go;
    logic [NUM_PORTS-1:0]           load_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_q;

    rw_arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (~rd_sel_n),
        .wr_req   (~wr_sel_n),
        .rd_go    (rd_go),
        .wr_go    (wr_go),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .rd_drop  (rd_drop),
        .wr_drop  (wr_drop)
    );

    assign load_v[PORT_RD] = rd_go;
    assign load_v[PORT_WR] = wr_go;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_addr
        rw_arb_addr_reg #(.W(ADDR_W)) u_areg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_v[p]),
            .d     (addr),
            .q     (addr_q[p])
        );
    end

    assign rd_addr = addr_q[PORT_RD];
    assign wr_addr = addr_q[PORT_WR];
endmodule

// File: rtl/rw_start_arbiter_chk.sv
module rw_start_arbiter_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_sel_n,
    input logic              wr_sel_n,
    input logic              rd_start,
    input logic              wr_start,
    input logic              rd_drop,
    input logic              wr_drop,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr
);
    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && wr_start)); // R7
    AST_NO_RD_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start); // R2
    AST_NO_WR_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start); // R2
    AST_IDLE_RD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_start && !wr_start && !rd_sel_n) |=> rd_start); // R3
    AST_AFTER_RD_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !rd_sel_n && !wr_sel_n) |=> wr_start); // R4
    AST_AFTER_WR_RD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !rd_sel_n && !wr_sel_n) |=> rd_start); // R5
    AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |-> $stable(rd_addr)); // R8
    AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_start |-> $stable(wr_addr)); // R8
    AST_RD_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drop |-> $past(rd_start)); // R9
    AST_WR_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> $past(wr_start)); // R9
    AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drop || wr_drop) |=> !($past(rd_drop) && rd_drop) && !($past(wr_drop) && wr_drop)); // R9
endmodule

bind rw_start_arbiter rw_start_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .rd_start (rd_start),
    .wr_start (wr_start),
    .rd_drop  (rd_drop),
    .wr_drop  (wr_drop),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr)
);

// File: tb/rw_start_arbiter_bench.sv
module rw_start_arbiter_bench;
    localparam int AW = 20;
    localparam int NV = 18;
    // {rd_req, wr_req, exp_rd_start, exp_wr_start, exp_rd_drop, exp_wr_drop}
    localparam logic [5:0] VEC [NV] = '{
        6'b00_0000, 6'b10_1000, 6'b10_0010, 6'b10_1000, 6'b00_0000,
        6'b01_0100, 6'b01_0001, 6'b01_0100, 6'b11_1001, 6'b11_0110,
        6'b11_1001, 6'b00_0000, 6'b11_1000, 6'b11_0110, 6'b10_1000,
        6'b01_0100, 6'b10_1000, 6'b00_0000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          rd_start, wr_start, rd_drop, wr_drop;
    logic [AW-1:0] rd_addr, wr_addr;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [AW-1:0] exp_ra = '0;
    logic [AW-1:0] exp_wa = '0;

    always #5 clk = ~clk;

    rw_start_arbiter #(.ADDR_W(AW)) u_rw_start_arbiter (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .rd_start(rd_start), .wr_start(wr_start),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .rd_drop(rd_drop), .wr_drop(wr_drop)
    );

    task automatic chk(input string tag, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            2, 6:      return "R2";
            8, 10:     return "R5";
            9, 13:     return "R4";
            12:        return "R3";
            14, 15, 16: return "R10";
            default:   return "R1";
        endcase
    endfunction

    task automatic step(input logic rq, input logic wq, input logic [AW-1:0] a);
        rd_sel_n = ~rq;
        wr_sel_n = ~wq;
        addr     = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "rd_start", AW'(rd_start), '0);
        chk("R11", "wr_start", AW'(wr_start), '0);
        chk("R11", "drops", AW'({rd_drop, wr_drop}), '0);
        chk("R11", "rd_addr", rd_addr, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] a;
            a = AW'(32'h1000 + i);
            step(VEC[i][5], VEC[i][4], a);
            if (VEC[i][3]) exp_ra = a;
            if (VEC[i][2]) exp_wa = a;
            chk(vtag(i), "rd_start", AW'(rd_start), AW'(VEC[i][3]));
            chk(vtag(i), "wr_start", AW'(wr_start), AW'(VEC[i][2]));
            chk("R9", "rd_drop", AW'(rd_drop), AW'(VEC[i][1]));
            chk("R9", "wr_drop", AW'(wr_drop), AW'(VEC[i][0]));
            chk("R7", "both_start", AW'(rd_start & wr_start), '0);
            chk("R8", "rd_addr", rd_addr, exp_ra);
            chk("R8", "wr_addr", wr_addr, exp_wa);
        end

        // R6: hold both selects from idle
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b1, AW'(32'h2000 + k));
            chk("R6", "rd_start", AW'(rd_start), AW'(k % 2 == 0));
            chk("R6", "wr_start", AW'(wr_start), AW'(k % 2 == 1));
        end

        // R11: reset in the middle of alternation, then restart from idle
        rst_n = 1'b0;
        #1;
        chk("R11", "rd_start", AW'(rd_start), '0);
        chk("R11", "wr_start", AW'(wr_start), '0);
        chk("R11", "wr_addr", wr_addr, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b1, AW'(32'h3abc));
        chk("R11", "rd_start", AW'(rd_start), 1);
        chk("R3", "wr_drop", AW'(wr_drop), '0);
        chk("R8", "rd_addr", rd_addr, AW'(32'h3abc));
        step(1'b0, 1'b0, AW'(32'h3fff));
        chk("R8", "rd_addr_hold", rd_addr, AW'(32'h3abc));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule